// File: doc/BRIEF.md
# Boundary-Scan Test Data Path

This block holds the test data registers behind a four-wire test port: a single-stage bypass register and a boundary register built from capture/update cells. An external test-port state machine supplies a register select and capture, shift and update strobes. The block moves serial data from `tdi` to `tdo` through whichever register is selected. On rising `tck` edges the selected register captures or shifts. On falling edges the update stages load and `tdo` is presented.

The boundary register has one data cell per device pin and one direction-control cell per pin group. A control cell holding 1 lets the pins of its group drive. A control cell holding 0 makes them inputs or high impedance. In test mode the pads and the core-side inputs take their values from the update stages. Outside test mode, functional values pass straight through and the chain has no visible effect.

Internally the strobes are decoded into one operation per cycle: OP_CAPTURE, OP_SHIFT, OP_UPDATE or OP_IDLE, with capture taking priority over shift and shift over update. The selects are decoded into SEL_BOUNDARY, SEL_BYPASS or SEL_NONE. The boundary select wins when both selects are high. The operation is re-evaluated every half cycle from the strobes; there are no transition conditions beyond that decode.

Top module: `bsr_data_path`

## Requirements
- R1: While `trst_n` is low, every update stage and the bypass stage read 0, and `tdo` and `tdo_oe` are 0. In test mode all `pad_oe` and `pad_out` bits are therefore 0.
- R2: With the boundary register selected and `shift_en` high, each rising `tck` edge moves every bit one place toward bit 0 and loads `tdi` into the top bit. Bits leave on `tdo` unchanged, in the order they entered.
- R3: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 after a falling edge at which `shift_en` was high and a register was selected, and 0 after one at which `shift_en` was low. `tdo` shows bit 0 of the selected register.
- R4: With only the bypass register selected, capture loads 0 into the single stage. Under shift, `tdi` appears on `tdo` one shift later. An update strobe leaves the boundary update stages untouched.
- R5: A capture on a rising edge loads each data cell from its `pad_in` bit and each control cell from its `core_grp_oe` bit.
- R6: The update stages take the boundary register contents on a falling `tck` edge only when `update_en` is high and the boundary register is selected. Otherwise they hold their value.
- R7: In test mode, `pad_oe[i]` equals the update value of the control cell for the group of pin i. The value 1 enables driving and 0 means input or high impedance.
- R8: With `test_mode` low, `pad_out` equals `core_out`, `pad_oe[i]` equals `core_grp_oe` of pin i's group, and `core_in` equals `pad_in`, whatever the chain holds.
- R9: With `test_mode` high, `pad_out[i]` and `core_in[i]` both equal the update value of data cell i.
- R10: With neither register selected, `tdo` and `tdo_oe` are 0 after every falling edge.
- R11: With the default layout, data cell i sits at chain bit i (bit 0 is nearest `tdo`) and control cell g at bit NUM_PINS+g. With the default grouping, pins 0 to 3 form group 0 and pins 4 to 7 form group 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data into the selected register |
| sel_bypass | input | 1 | Selects the bypass register |
| sel_boundary | input | 1 | Selects the boundary register |
| capture_en | input | 1 | Parallel capture on the rising edge |
| shift_en | input | 1 | Shift on the rising edge |
| update_en | input | 1 | Update stages load on the falling edge |
| test_mode | input | 1 | Pads and core take values from the update stages |
| pad_in | input | NUM_PINS | Values seen at the pads |
| core_out | input | NUM_PINS | Functional values the core drives to the pads |
| core_grp_oe | input | NUM_GROUPS | Functional output enables, one per pin group |
| tdo | output | 1 | Serial data out, changes on falling edges |
| tdo_oe | output | 1 | Enable for the `tdo` driver |
| pad_out | output | NUM_PINS | Value driven to each pad |
| pad_oe | output | NUM_PINS | Output enable for each pad |
| core_in | output | NUM_PINS | Value presented to the core |

## Verification
Some properties can be checked at every clock edge, and the assertions cover these. They check the safe reset state and that `tdo_oe` follows shift activity one falling edge later. They also check that `tdo` stays quiet when no register is selected, that functional values pass through outside test mode, and that the pads hold steady when no update is strobed. Other behaviour needs a known history of stimulus, so only the bench scenarios show it. This includes the captured values and their bit order on `tdo`, the end-to-end transfer without inversion, the one-stage delay of the bypass path, and the mapping of control cells to pin groups.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2,
        OP_UPDATE  = 2'd3
    } bsr_op_e;

    typedef enum logic [1:0] {
        SEL_NONE     = 2'd0,
        SEL_BYPASS   = 2'd1,
        SEL_BOUNDARY = 2'd2
    } bsr_sel_e;

endpackage

// File: rtl/bsr_master_chain.sv
module bsr_master_chain #(
    parameter int LEN = 10
) (
    input  logic           tck,
    input  logic           cap_go,
    input  logic           shf_go,
    input  logic           tdi,
    input  logic [LEN-1:0] par_in,
    output logic [LEN-1:0] master
);
    // Capture and shift stages: rising edge, no reset needed.
    always_ff @(posedge tck) begin
        if (cap_go) begin
            master <= par_in;
        end else if (shf_go) begin
            master <= {tdi, master[LEN-1:1]};
        end
    end
endmodule

// File: rtl/bsr_update_bank.sv
module bsr_update_bank #(
    parameter int LEN = 10
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           upd_go,
    input  logic [LEN-1:0] master,
    output logic [LEN-1:0] slave
);
    // Update stages: falling edge, reset to the safe all-zero state.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            slave <= '0;
        end else if (upd_go) begin
            slave <= master;
        end
    end
endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux #(
    parameter int                        NUM_PINS   = 8,
    parameter int                        NUM_GROUPS = 2,
    parameter int                        GRP_W      = 1,
    parameter logic [NUM_PINS*GRP_W-1:0] PIN_GROUP  = '0
) (
    input  logic                  test_mode,
    input  logic [NUM_PINS-1:0]   upd_data,
    input  logic [NUM_GROUPS-1:0] upd_ctrl,
    input  logic [NUM_PINS-1:0]   pad_in,
    input  logic [NUM_PINS-1:0]   core_out,
    input  logic [NUM_GROUPS-1:0] core_grp_oe,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   core_in
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int GI = int'(PIN_GROUP[i*GRP_W +: GRP_W]);
        always_comb begin
            if (test_mode) begin
                pad_out[i] = upd_data[i];
                pad_oe[i]  = upd_ctrl[GI];
                core_in[i] = upd_data[i];
            end else begin
                pad_out[i] = core_out[i];
                pad_oe[i]  = core_grp_oe[GI];
                core_in[i] = pad_in[i];
            end
        end
    end
endmodule

// File: rtl/bsr_data_path.sv
module bsr_data_path #(
    parameter int NUM_PINS    = 8,
    parameter int NUM_GROUPS  = 2,
    parameter int GRP_W       = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    parameter logic [NUM_PINS*GRP_W-1:0] PIN_GROUP = 8'hF0,
    parameter bit CTRL_AT_TDO = 1'b0
) (
    input  logic                  tck,
    input  logic                  trst_n,
    input  logic                  tdi,
    input  logic                  sel_bypass,
    input  logic                  sel_boundary,
    input  logic                  capture_en,
    input  logic                  shift_en,
    input  logic                  update_en,
    input  logic                  test_mode,
    input  logic [NUM_PINS-1:0]   pad_in,
    input  logic [NUM_PINS-1:0]   core_out,
    input  logic [NUM_GROUPS-1:0] core_grp_oe,
    output logic                  tdo,
    output logic                  tdo_oe,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   core_in
);
    import bsr_pkg::*;

    localparam int LEN = NUM_PINS + NUM_GROUPS;

    bsr_op_e  op;
    bsr_sel_e sel_state;
    logic     bsr_cap, bsr_shf, byp_cap, byp_shf, upd_go;
    logic     byp_q, tdo_q, tdo_oe_q;

    logic [LEN-1:0]        cap_vec, master, slave;
    logic [NUM_PINS-1:0]   upd_data;
    logic [NUM_GROUPS-1:0] upd_ctrl;

    // Strobe and select decode.
    always_comb begin
        if (capture_en)     op = OP_CAPTURE;
        else if (shift_en)  op = OP_SHIFT;
        else if (update_en) op = OP_UPDATE;
        else                op = OP_IDLE;

        if (sel_boundary)    sel_state = SEL_BOUNDARY;
        else if (sel_bypass) sel_state = SEL_BYPASS;
        else                 sel_state = SEL_NONE;
    end

    // Per-operation strobes to the registers.
    always_comb begin
        bsr_cap = 1'b0;
        bsr_shf = 1'b0;
        byp_cap = 1'b0;
        byp_shf = 1'b0;
        upd_go  = 1'b0;
        unique case (op)
            OP_IDLE: begin
            end
            OP_CAPTURE: begin
                bsr_cap = (sel_state == SEL_BOUNDARY);
                byp_cap = (sel_state == SEL_BYPASS);
            end
            OP_SHIFT: begin
                bsr_shf = (sel_state == SEL_BOUNDARY);
                byp_shf = (sel_state == SEL_BYPASS);
            end
            OP_UPDATE: begin
                upd_go = (sel_state == SEL_BOUNDARY);
            end
        endcase
    end

    // Chain layout variant: control cells nearest TDO or above the data cells.
    if (CTRL_AT_TDO) begin : g_ctrl_low
        assign cap_vec  = {pad_in, core_grp_oe};
        assign upd_data = slave[LEN-1:NUM_GROUPS];
        assign upd_ctrl = slave[NUM_GROUPS-1:0];
    end else begin : g_ctrl_high
        assign cap_vec  = {core_grp_oe, pad_in};
        assign upd_data = slave[NUM_PINS-1:0];
        assign upd_ctrl = slave[LEN-1:NUM_PINS];
    end

    bsr_master_chain #(.LEN(LEN)) u_chain (
        .tck    (tck),
        .cap_go (bsr_cap),
        .shf_go (bsr_shf),
        .tdi    (tdi),
        .par_in (cap_vec),
        .master (master)
    );

    bsr_update_bank #(.LEN(LEN)) u_update (
        .tck    (tck),
        .trst_n (trst_n),
        .upd_go (upd_go),
        .master (master),
        .slave  (slave)
    );

    bsr_pin_mux #(
        .NUM_PINS   (NUM_PINS),
        .NUM_GROUPS (NUM_GROUPS),
        .GRP_W      (GRP_W),
        .PIN_GROUP  (PIN_GROUP)
    ) u_pins (
        .test_mode   (test_mode),
        .upd_data    (upd_data),
        .upd_ctrl    (upd_ctrl),
        .pad_in      (pad_in),
        .core_out    (core_out),
        .core_grp_oe (core_grp_oe),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .core_in     (core_in)
    );

    // Bypass stage.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)      byp_q <= 1'b0;
        else if (byp_cap) byp_q <= 1'b0;
        else if (byp_shf) byp_q <= tdi;
    end

    // Serial output, presented on the falling edge.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q    <= 1'b0;
            tdo_oe_q <= 1'b0;
        end else begin
            unique case (sel_state)
                SEL_BOUNDARY: tdo_q <= master[0];
                SEL_BYPASS:   tdo_q <= byp_q;
                default:      tdo_q <= 1'b0;
            endcase
            tdo_oe_q <= (op == OP_SHIFT) && (sel_state != SEL_NONE);
        end
    end

    assign tdo    = tdo_q;
    assign tdo_oe = tdo_oe_q;

endmodule

// File: rtl/bsr_data_path_chk.sv
module bsr_data_path_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                tck,
    input logic                trst_n,
    input logic                sel_bypass,
    input logic                sel_boundary,
    input logic                shift_en,
    input logic                update_en,
    input logic                test_mode,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] core_out,
    input logic                tdo,
    input logic                tdo_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] core_in
);
    always @(posedge tck) begin
        if (!trst_n) begin
            assert_reset_safe_R1: assert (tdo_oe == 1'b0 && tdo == 1'b0 &&
                                          (!test_mode || (pad_oe == '0 && pad_out == '0)));
        end
    end

    assert_tdo_oe_follows_shift_R3: assert property (
        @(negedge tck) disable iff (!trst_n)
        (shift_en && (sel_boundary || sel_bypass)) |=> tdo_oe);

    assert_tdo_quiet_unselected_R10: assert property (
        @(negedge tck) disable iff (!trst_n)
        !(sel_boundary || sel_bypass) |=> (!tdo_oe && !tdo));

    assert_functional_passthrough_R8: assert property (
        @(posedge tck) disable iff (!trst_n)
        !test_mode |-> (pad_out == core_out && core_in == pad_in));

    assert_update_hold_R6: assert property (
        @(negedge tck) disable iff (!trst_n)
        (test_mode && !update_en) |=> (!test_mode || $stable(pad_out)));

endmodule

bind bsr_data_path bsr_data_path_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .tck          (tck),
    .trst_n       (trst_n),
    .sel_bypass   (sel_bypass),
    .sel_boundary (sel_boundary),
    .shift_en     (shift_en),
    .update_en    (update_en),
    .test_mode    (test_mode),
    .pad_in       (pad_in),
    .core_out     (core_out),
    .tdo          (tdo),
    .tdo_oe       (tdo_oe),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .core_in      (core_in)
);

// File: tb/tb_bsr_data_path.sv
module tb_bsr_data_path;

    localparam int P = 8;
    localparam int G = 2;
    localparam int L = P + G;
    localparam int NV = 4;

    // {pad_in, core_grp_oe, scan data}
    localparam logic [19:0] VEC [NV] = '{
        {8'hA5, 2'b01, 10'h23C},
        {8'h3C, 2'b10, 10'h1C3},
        {8'hFF, 2'b11, 10'h355},
        {8'h00, 2'b00, 10'h0FF}
    };

    logic tck = 1'b0;
    logic trst_n = 1'b1;
    logic tdi = 1'b0, sel_bypass = 1'b0, sel_boundary = 1'b0;
    logic capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, test_mode = 1'b1;
    logic [P-1:0] pad_in = '0, core_out = '0;
    logic [G-1:0] core_grp_oe = '0;
    logic tdo, tdo_oe;
    logic [P-1:0] pad_out, pad_oe, core_in;

    int n_chk = 0;
    int n_fail = 0;

    logic s_tdo, s_oe, r_tdo;
    logic [P-1:0] s_pout, s_poe, s_cin;

    always #2 tck = ~tck;

    bsr_data_path dut (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .sel_bypass(sel_bypass), .sel_boundary(sel_boundary),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .test_mode(test_mode), .pad_in(pad_in), .core_out(core_out),
        .core_grp_oe(core_grp_oe), .tdo(tdo), .tdo_oe(tdo_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One test-clock cycle: drive, sample after the falling edge, then after the rising edge.
    task automatic step(input logic c, input logic s, input logic u, input logic d);
        capture_en = c; shift_en = s; update_en = u; tdi = d;
        @(negedge tck); #1;
        s_tdo = tdo; s_oe = tdo_oe; s_pout = pad_out; s_poe = pad_oe; s_cin = core_in;
        @(posedge tck); #1;
        r_tdo = tdo;
    endtask

    function automatic logic [P-1:0] exp_oe(input logic [G-1:0] ctrl);
        logic [P-1:0] r;
        for (int i = 0; i < P; i++) r[i] = ctrl[i / 4];
        return r;
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] prev_d;
        logic [1:0] prev_c;
        logic [7:0] pin;
        logic [1:0] goe;
        logic [9:0] scan, cap;

        // R1: reset state
        #1 trst_n = 1'b0;
        repeat (3) @(posedge tck);
        #1;
        check("R1 pad_oe in reset", pad_oe, 8'h00);
        check("R1 pad_out in reset", pad_out, 8'h00);
        check("R1 tdo_oe in reset", tdo_oe, 1'b0);
        check("R1 tdo in reset", tdo, 1'b0);
        trst_n = 1'b1;
        @(posedge tck); #1;

        prev_d = 8'h00;
        prev_c = 2'b00;

        // Vector table: capture, shift, hold, update, shift-through.
        for (int v = 0; v < NV; v++) begin
            {pin, goe, scan} = VEC[v];
            pad_in = pin; core_grp_oe = goe;
            sel_boundary = 1'b1; sel_bypass = 1'b0; test_mode = 1'b1;
            cap = {goe, pin};
            step(1'b1, 1'b0, 1'b0, 1'b0);
            check("R3 tdo_oe low outside shift", s_oe, 1'b0);
            for (int k = 0; k < L; k++) begin
                step(1'b0, 1'b1, 1'b0, scan[k]);
                check("R5 R11 captured bit on tdo", s_tdo, cap[k]);
                check("R3 tdo_oe high while shifting", s_oe, 1'b1);
                check("R3 tdo stable at rising edge", r_tdo, s_tdo);
            end
            step(1'b0, 1'b0, 1'b0, 1'b0);
            check("R6 pad_out held without update", s_pout, prev_d);
            check("R6 pad_oe held without update", s_poe, exp_oe(prev_c));
            step(1'b0, 1'b0, 1'b1, 1'b0);
            check("R9 pad_out from update stage", s_pout, scan[7:0]);
            check("R9 core_in from update stage", s_cin, scan[7:0]);
            check("R7 R11 group enables", s_poe, exp_oe(scan[9:8]));
            prev_d = scan[7:0];
            prev_c = scan[9:8];
            for (int k = 0; k < L; k++) begin
                step(1'b0, 1'b1, 1'b0, 1'b0);
                check("R2 shifted data emerges uninverted", s_tdo, scan[k]);
            end
        end

        // R8: functional mode passes core and pad values through.
        test_mode = 1'b0;
        core_out = 8'h5A; core_grp_oe = 2'b10; pad_in = 8'hC3;
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 pad_out functional", s_pout, 8'h5A);
        check("R8 pad_oe functional", s_poe, 8'hF0);
        check("R8 core_in functional", s_cin, 8'hC3);
        scan = 10'h3A5;
        step(1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < L; k++) step(1'b0, 1'b1, 1'b0, scan[k]);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check("R8 pad_out unaffected by update", s_pout, 8'h5A);
        check("R8 core_in unaffected by update", s_cin, 8'hC3);
        test_mode = 1'b1;
        #1;
        check("R9 test mode takes loaded data", pad_out, 8'hA5);
        check("R7 both groups enabled", pad_oe, 8'hFF);

        // R4: bypass path.
        sel_boundary = 1'b0; sel_bypass = 1'b1;
        step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b1);
        check("R4 bypass captured zero", s_tdo, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b1);
        check("R4 bypass one-stage delay b0", s_tdo, 1'b1);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check("R4 bypass one-stage delay b1", s_tdo, 1'b1);
        step(1'b0, 1'b1, 1'b0, 1'b1);
        check("R4 bypass one-stage delay b2", s_tdo, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check("R4 update ignored under bypass", s_pout, 8'hA5);

        // R10: nothing selected.
        sel_bypass = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b1, 1'b0, 1'b1);
            check("R10 tdo_oe low unselected", s_oe, 1'b0);
            check("R10 tdo low unselected", s_tdo, 1'b0);
        end
        shift_en = 1'b0;

        // R1: reset after the update stages were loaded.
        trst_n = 1'b0;
        #1;
        check("R1 pad_oe after mid-run reset", pad_oe, 8'h00);
        check("R1 pad_out after mid-run reset", pad_out, 8'h00);
        check("R1 tdo_oe after mid-run reset", tdo_oe, 1'b0);
        @(posedge tck); #1;
        trst_n = 1'b1;
        @(posedge tck); #1;

        finish_run();
    end

endmodule